// File: doc/BRIEF.md
# Camera Register Initialisation Writer

This block programs a camera sensor once after power-up. When reset is released it walks a fixed list of ten register/value pairs. For each pair it sends one write transaction on a two-wire serial control bus. A transaction has three byte phases: the device write ID, the register address, and the value. Each byte goes out MSB first and is followed by a ninth bit, which the master drives high without sampling any reply.

Both bus lines are push-pull outputs, so no pull-ups are needed and the bus is never tri-stated. Reads are not supported. Once the last pair has been sent, the block stays in a terminal state with both lines idle high until the next reset.

The serial clock comes from the system clock through a quarter-bit divider. With the default 50 MHz clock and `QTR_CYCLES` = 125, the bus runs at 100 kHz.

Top module: `cam_cfg_writer`

## Requirements
- R1: While rst_ni is low, scl_o and sda_o are 1, and busy_o and done_o are 0.
- R2: Exactly ten writes are issued, in this order, written as register:value: 0x11:0x00, 0x12:0x04, 0x0C:0x00, 0x3E:0x00, 0x70:0x3A, 0x71:0x35, 0x72:0x11, 0x73:0xF0, 0xA2:0x02, 0x40:0xD0.
- R3: Each write sends three bytes, each MSB first: the device ID 0x42 (parameter DEV_ID), then the register address, then the value.
- R4: After every byte, the ninth bit on sda_o is 1, and no bus input is sampled.
- R5: A write opens with sda_o falling while scl_o is high. It closes with sda_o rising while scl_o is high. Between these two, sda_o changes only while scl_o is low, and exactly 27 data-bit clock pulses occur.
- R6: Within a write, consecutive rising edges of scl_o are 4*QTR_CYCLES clocks apart, and each data-bit high phase of scl_o lasts 2*QTR_CYCLES clocks.
- R7: busy_o is 1 from the first clock after reset release until the last write's stop condition. After that, done_o stays 1, busy_o stays 0, and both lines stay at 1 with no edges until reset.
- R8: A reset applied in the middle of a write aborts that write. After release, the sequence restarts from the first table entry and completes all ten writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_o | output | 1 | Serial bus clock, push-pull |
| sda_o | output | 1 | Serial bus data, push-pull |
| busy_o | output | 1 | Configuration sequence in progress |
| done_o | output | 1 | All table entries written; sticky until reset |

## Verification
The bench decodes the bus from its own sampled line values and compares every decoded frame with the expected table. A design that sent pairs out of order, repeated the first entry or stopped early would fail the per-entry and count checks. A design that let the ninth bit fall to 0, or changed data while the clock was high (which creates a false start or stop), would fail the ninth-bit or framing checks. The bench also aborts a write partway through the fourth entry. A sequencer that kept its table index over reset would then resume from the wrong pair, and a divider that drifted would break the rise-to-rise spacing check.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

  localparam int unsigned CFG_ENTRIES = 10;
  localparam int unsigned SLOT_BITS   = 9;   // byte plus trailing ninth bit
  localparam int unsigned FRAME_BITS  = 3 * SLOT_BITS;

  typedef enum logic [1:0] {SER_IDLE, SER_START, SER_BITS, SER_STOP} ser_state_e;
  typedef enum logic [1:0] {SEQ_INIT, SEQ_RUN, SEQ_DONE} seq_state_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] value;
  } cfg_pair_t;

  function automatic cfg_pair_t cfg_entry(input int unsigned idx);
    cfg_pair_t p;
    case (idx)
      0:       p = '{addr: 8'h11, value: 8'h00};  // clock prescale
      1:       p = '{addr: 8'h12, value: 8'h04};  // output format select
      2:       p = '{addr: 8'h0C, value: 8'h00};  // scaling enable
      3:       p = '{addr: 8'h3E, value: 8'h00};  // pixel clock divide mode
      4:       p = '{addr: 8'h70, value: 8'h3A};  // horizontal scale / pattern
      5:       p = '{addr: 8'h71, value: 8'h35};  // vertical scale / pattern
      6:       p = '{addr: 8'h72, value: 8'h11};  // downsample control
      7:       p = '{addr: 8'h73, value: 8'hF0};  // pixel clock divider
      8:       p = '{addr: 8'hA2, value: 8'h02};  // pixel clock delay
      default: p = '{addr: 8'h40, value: 8'hD0};  // output range / 565 select
    endcase
    return p;
  endfunction

  function automatic logic is_ack_slot(input int unsigned bit_idx);
    return (bit_idx % SLOT_BITS) == (SLOT_BITS - 1);
  endfunction

endpackage

// File: rtl/cam_cfg_tick.sv
module cam_cfg_tick #(
  parameter int unsigned QTR_CYCLES = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned CNT_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QTR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CNT_LAST);

  // R6: quarter ticks are never back to back
  a_r6_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/cam_cfg_serializer.sv
module cam_cfg_serializer
  import cam_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h42
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       end_o
);

  localparam int unsigned NBIT_W = $clog2(FRAME_BITS);
  localparam logic [NBIT_W-1:0] NBIT_LAST = NBIT_W'(FRAME_BITS - 1);

  ser_state_e            st_q;
  logic [1:0]            q_q;
  logic [NBIT_W-1:0]     nbit_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  scl_n, sda_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SER_IDLE;
      q_q    <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
    end else if (tick_i) begin
      unique case (st_q)
        SER_IDLE: if (start_i) begin
          sh_q <= {DEV_ID, 1'b1, addr_i, 1'b1, data_i, 1'b1};
          st_q <= SER_START;
          q_q  <= '0;
        end
        SER_START: if (q_q == 2'd1) begin
          st_q   <= SER_BITS;
          q_q    <= '0;
          nbit_q <= '0;
        end else q_q <= q_q + 2'd1;
        SER_BITS: if (q_q == 2'd3) begin
          q_q <= '0;
          if (nbit_q == NBIT_LAST) st_q <= SER_STOP;
          else begin
            nbit_q <= nbit_q + 1'b1;
            sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b0};
          end
        end else q_q <= q_q + 2'd1;
        SER_STOP: if (q_q == 2'd3) begin
          st_q <= SER_IDLE;
          q_q  <= '0;
        end else q_q <= q_q + 2'd1;
        default: st_q <= SER_IDLE;
      endcase
    end
  end

  // quarter 0 holds data while the clock falls; data moves in quarter 1
  always_comb begin
    scl_n = 1'b1;
    sda_n = 1'b1;
    unique case (st_q)
      SER_IDLE:  begin scl_n = 1'b1;   sda_n = 1'b1; end
      SER_START: begin scl_n = 1'b1;   sda_n = (q_q == 2'd0); end
      SER_BITS:  begin
        scl_n = q_q[1];
        sda_n = (q_q == 2'd0) ? sda_o : sh_q[FRAME_BITS-1];
      end
      SER_STOP:  begin
        scl_n = q_q[1];
        sda_n = (q_q == 2'd3) ? 1'b1 : ((q_q == 2'd0) ? sda_o : 1'b0);
      end
      default:   begin scl_n = 1'b1;   sda_n = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_o <= 1'b1;
      sda_o <= 1'b1;
    end else begin
      scl_o <= scl_n;
      sda_o <= sda_n;
    end
  end

  assign end_o = tick_i && (st_q == SER_STOP) && (q_q == 2'd3);

  // R5: data edges under a high clock only come from start or stop framing
  a_r5_sda_edge_framing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o)))
      |-> ($past(st_q) == SER_START || $past(st_q) == SER_STOP));

  // R4: every ninth slot of the loaded frame carries a 1
  a_r4_ninth_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SER_BITS && q_q != 2'd0 && is_ack_slot(int'(nbit_q)))
      |-> sh_q[FRAME_BITS-1]);

  // R5: clock only low inside a transaction
  a_r5_idle_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == SER_IDLE) |-> scl_o);

endmodule

// File: rtl/cam_cfg_writer.sv
module cam_cfg_writer
  import cam_cfg_pkg::*;
#(
  parameter int unsigned QTR_CYCLES = 125,
  parameter logic [7:0]  DEV_ID     = 8'h42
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic scl_o,
  output logic sda_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned IDX_W = $clog2(CFG_ENTRIES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CFG_ENTRIES - 1);

  seq_state_e       seq_q;
  logic [IDX_W-1:0] idx_q;
  logic             tick, frame_end;
  cfg_pair_t        pair;

  cam_cfg_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign pair = cfg_entry(int'(idx_q));

  cam_cfg_serializer #(.DEV_ID(DEV_ID)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (seq_q == SEQ_RUN),
    .addr_i  (pair.addr),
    .data_i  (pair.value),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .end_o   (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SEQ_INIT;
      idx_q <= '0;
    end else begin
      unique case (seq_q)
        SEQ_INIT: seq_q <= SEQ_RUN;
        SEQ_RUN: if (frame_end) begin
          if (idx_q == IDX_LAST) seq_q <= SEQ_DONE;
          else                   idx_q <= idx_q + 1'b1;
        end
        SEQ_DONE: seq_q <= SEQ_DONE;
        default:  seq_q <= SEQ_INIT;
      endcase
    end
  end

  assign busy_o = (seq_q == SEQ_RUN);
  assign done_o = (seq_q == SEQ_DONE);

  // R7: terminal state is sticky
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R7: bus rests high once finished
  a_r7_done_lines_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scl_o && sda_o));

  // R7: busy and done never overlap
  a_r7_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R2: index stays within the table
  a_r2_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);

  // R2: index only moves at the end of a write
  a_r2_idx_steps_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != $past(idx_q)) |-> $past(frame_end));

endmodule

// File: tb/cam_cfg_writer_test.sv
module cam_cfg_writer_test;

  localparam int unsigned Q  = 4;
  localparam int unsigned WD = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl, sda, busy, done;

  always #10 clk = ~clk;

  cam_cfg_writer #(.QTR_CYCLES(Q), .DEV_ID(8'h42)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_o(scl), .sda_o(sda),
    .busy_o(busy), .done_o(done)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_addr [10];
  logic [7:0] exp_data [10];

  // bus monitor state
  int   cyc = 0;
  int   mon_txn = 0, mon_bits = 0, mon_in_tx = 0;
  int   mon_frame_err = 0, mon_time_err = 0, mon_ninth_err = 0, mon_edges = 0;
  int   last_rise = 0;
  logic [26:0] mon_frame = '0;
  logic [7:0]  rx_id [16];
  logic [7:0]  rx_addr [16];
  logic [7:0]  rx_data [16];
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  task automatic mon_clear();
    mon_txn = 0; mon_bits = 0; mon_in_tx = 0;
    mon_frame_err = 0; mon_time_err = 0; mon_ninth_err = 0; mon_edges = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WD);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_ni) begin
      if (scl != prev_scl || sda != prev_sda) mon_edges++;
      if (prev_scl && scl && prev_sda && !sda) begin
        if (mon_in_tx != 0) mon_frame_err++;
        mon_in_tx = 1; mon_bits = 0;
      end else if (prev_scl && scl && !prev_sda && sda) begin
        if (mon_in_tx == 0 || mon_bits != 27) mon_frame_err++;
        else if (mon_txn < 16) begin
          rx_id[mon_txn]   = mon_frame[26:19];
          rx_addr[mon_txn] = mon_frame[17:10];
          rx_data[mon_txn] = mon_frame[8:1];
          if (!(mon_frame[18] && mon_frame[9] && mon_frame[0])) mon_ninth_err++;
        end
        mon_txn++; mon_in_tx = 0;
      end else if (!prev_scl && scl) begin
        if (mon_in_tx == 0) mon_frame_err++;
        if (mon_bits > 0 && (cyc - last_rise) != 4 * Q) mon_time_err++;
        last_rise = cyc;
        if (mon_bits < 27) begin
          mon_frame = {mon_frame[25:0], sda};
          mon_bits++;
        end
      end else if (prev_scl && !scl) begin
        if (mon_bits > 0 && (cyc - last_rise) != 2 * Q) mon_time_err++;
      end
    end
    prev_scl = scl;
    prev_sda = sda;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl == 1'b1, "R1 scl in reset", 32'(scl), 1);
    chk(sda == 1'b1, "R1 sda in reset", 32'(sda), 1);
    chk(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", 32'(done), 0);
  endtask

  task automatic t_full_sequence();
    int id_bad = 0;
    mon_clear();
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after release", 32'(busy), 1);
    while (!done) @(negedge clk);
    chk(mon_txn == 10, "R2 write count", 32'(mon_txn), 10);
    for (int i = 0; i < 10; i++) begin
      chk(rx_addr[i] == exp_addr[i], $sformatf("R2 entry %0d address", i),
          32'(rx_addr[i]), 32'(exp_addr[i]));
      chk(rx_data[i] == exp_data[i], $sformatf("R2 entry %0d value", i),
          32'(rx_data[i]), 32'(exp_data[i]));
      if (rx_id[i] != 8'h42) id_bad++;
    end
    chk(id_bad == 0, "R3 device ID first byte", 32'(id_bad), 0);
    chk(mon_ninth_err == 0, "R4 ninth bits high", 32'(mon_ninth_err), 0);
    chk(mon_frame_err == 0, "R5 start/stop framing", 32'(mon_frame_err), 0);
    chk(mon_time_err == 0, "R6 clock spacing", 32'(mon_time_err), 0);
    chk(busy == 1'b0, "R7 busy low when done", 32'(busy), 0);
  endtask

  task automatic t_quiet_after_done();
    int e0 = mon_edges;
    repeat (1000) @(negedge clk);
    chk(mon_edges == e0, "R7 no bus edges after done", 32'(mon_edges - e0), 0);
    chk(done == 1'b1 && busy == 1'b0, "R7 done sticky", {30'b0, done, busy}, 32'b10);
    chk(scl && sda, "R7 lines idle high", {30'b0, scl, sda}, 32'b11);
  endtask

  task automatic t_reset_midframe();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    mon_clear();
    rst_ni = 1'b1;
    while (!(mon_txn == 3 && mon_bits >= 12)) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(scl && sda && !busy, "R1 abort reset state", {29'b0, scl, sda, busy}, 32'b110);
    @(negedge clk);
    mon_clear();
    rst_ni = 1'b1;
    while (!done) @(negedge clk);
    chk(mon_txn == 10, "R8 restart count", 32'(mon_txn), 10);
    chk(rx_addr[0] == exp_addr[0] && rx_data[0] == exp_data[0],
        "R8 restart from first entry", {16'b0, rx_addr[0], rx_data[0]},
        {16'b0, exp_addr[0], exp_data[0]});
    chk(rx_addr[9] == exp_addr[9], "R8 last entry after restart",
        32'(rx_addr[9]), 32'(exp_addr[9]));
    chk(mon_frame_err == 0, "R5 framing after restart", 32'(mon_frame_err), 0);
  endtask

  initial begin
    exp_addr = '{8'h11, 8'h12, 8'h0C, 8'h3E, 8'h70, 8'h71, 8'h72, 8'h73, 8'hA2, 8'h40};
    exp_data = '{8'h00, 8'h04, 8'h00, 8'h00, 8'h3A, 8'h35, 8'h11, 8'hF0, 8'h02, 8'hD0};
    t_reset_state();
    t_full_sequence();
    t_quiet_after_done();
    t_reset_midframe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule